// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-rank SDR SDRAM from power-up to normal operation. Once reset is released it raises clock enable and holds the command bus at NOP for a stabilization wait. It then issues a precharge of all banks, followed by a series of auto-refresh commands. It finishes with a load-mode-register command that programs a burst-of-8, sequential, CAS-latency-2 mode word. The gap after each command is a minimum time given in nanoseconds. It is turned into clock cycles from the clock frequency parameter, rounding up, with a floor of one cycle.

A mode input picks one of two sequences. The short sequence waits 100 µs and issues two refreshes. The long sequence waits 200 µs and issues eight refreshes. When the mode register has settled, the block gives a one-cycle completion pulse and a sticky ready level. It then raises a refresh request every refresh interval. Each request stays up until the memory controller acknowledges it. The block does not cover the read/write datapath, bank tracking or arbitration.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, cke_o is 0, the command bus {cs_n,ras_n,cas_n,we_n} is 4'b1111 (inhibit), addr_o is 0, and ready_o, init_done_o and refresh_req_o are 0.
- R2: From the first clock after reset release, cke_o is 1 and stays 1. The command bus carries NOP (4'b0111) for exactly the wait length: 10000 cycles in short mode and 20000 cycles in long mode at 100 MHz.
- R3: Exactly one precharge-all (4'b0010) is issued, with addr_o bit 10 set. It comes in the cycle right after the wait.
- R4: Auto-refresh (4'b0001) is issued 2 times when mode_i=0 and 8 times when mode_i=1. The first comes tRP cycles after the precharge and the rest follow every tRFC cycles.
- R5: Load-mode (4'b0000) comes tRFC cycles after the last refresh, with ba_o=0 and addr_o=13'h023. Bits [2:0]=3 select burst 8, bit 3=0 selects sequential and bits [6:4]=2 select CAS latency 2.
- R6: Each spacing equals ceil(ns * CLK_HZ / 1e9), with a minimum of one. At 100 MHz this gives tRP=2, tRFC=7, tMRD=2 and a refresh interval of 782 cycles.
- R7: ready_o rises tMRD cycles after load-mode and then stays high. init_done_o is high in that first ready cycle only.
- R8: mode_i is sampled only at the first clock after reset release. Later changes do not alter the sequence.
- R9: refresh_req_o stays low before ready_o. It rises 782 cycles after ready_o rises and again at every multiple of 782 after that.
- R10: refresh_req_o stays high until refresh_ack_i is seen, and is low in the cycle after the ack. An ack while no request is pending has no effect.
- R11: Once ready_o is high, the block drives only NOP on the command bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: short sequence, 1: long sequence |
| refresh_ack_i | input | 1 | Acknowledges a pending refresh request |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus (A10 / mode word) |
| ba_o | output | BA_W | Bank address |
| ready_o | output | 1 | Initialization complete (level) |
| init_done_o | output | 1 | Initialization complete (one-cycle pulse) |
| refresh_req_o | output | 1 | Periodic refresh request |

## Verification
All outputs come from registers, so each result is due at a fixed cycle offset from the first sampled cycle after reset release (t=0). The precharge is due at t=W, where W is the wait length. Refresh k is due at t=W+2+7k, load-mode at t=W+2+7N, and ready with the completion pulse at t=W+4+7N. The first refresh request is due 782 cycles after ready rises. An ack clears the request in the next sampled cycle. The bench drives inputs and samples outputs one time unit after each rising edge. It compares the whole command stream cycle by cycle against a schedule it computes from these offsets, so a command that comes one cycle early or late is reported.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'b1111,
    CMD_NOP     = 4'b0111,
    CMD_PRE     = 4'b0010,
    CMD_REF     = 4'b0001,
    CMD_LMR     = 4'b0000
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_REF,
    ST_MRD,
    ST_RUN
  } init_state_e;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic int unsigned ns2cyc(input longint unsigned ns, input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BA_W        = 2,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned WAIT_S_CYC  = 10000,
  parameter int unsigned WAIT_L_CYC  = 20000,
  parameter int unsigned REFS_S      = 2,
  parameter int unsigned REFS_L      = 8,
  parameter int unsigned TRP_CYC     = 2,
  parameter int unsigned TRFC_CYC    = 7,
  parameter int unsigned TMRD_CYC    = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              zero_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              cke_o,
  output sdram_cmd_e        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ready_o,
  output logic              done_o
);

  localparam int unsigned REFS_MAX = (REFS_L > REFS_S) ? REFS_L : REFS_S;
  localparam int unsigned RC_W     = $clog2(REFS_MAX + 1);
  localparam int unsigned AP_BIT   = 10;

  init_state_e       state_q;
  logic              long_q;
  logic [RC_W-1:0]   ref_cnt_q;
  logic [RC_W-1:0]   ref_target;
  logic              more_refs;

  assign ref_target = long_q ? RC_W'(REFS_L) : RC_W'(REFS_S);
  assign more_refs  = (ref_cnt_q < ref_target);

  // timer reload: spacing minus one, since the loading cycle counts
  always_comb begin
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        load_o     = 1'b1;
        load_val_o = mode_i ? CNT_W'(WAIT_L_CYC - 1) : CNT_W'(WAIT_S_CYC - 1);
      end
      ST_WAIT: begin
        load_o     = zero_i;
        load_val_o = CNT_W'(TRP_CYC - 1);
      end
      ST_PRE: begin
        load_o     = zero_i;
        load_val_o = CNT_W'(TRFC_CYC - 1);
      end
      ST_REF: begin
        load_o     = zero_i;
        load_val_o = more_refs ? CNT_W'(TRFC_CYC - 1) : CNT_W'(TMRD_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      long_q    <= 1'b0;
      ref_cnt_q <= '0;
      cke_o     <= 1'b0;
      cmd_o     <= CMD_INHIBIT;
      addr_o    <= '0;
      ba_o      <= '0;
      ready_o   <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      cmd_o  <= CMD_NOP;
      addr_o <= '0;
      ba_o   <= '0;
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cke_o   <= 1'b1;
          long_q  <= mode_i;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (zero_i) begin
          cmd_o          <= CMD_PRE;
          addr_o[AP_BIT] <= 1'b1;
          state_q        <= ST_PRE;
        end
        ST_PRE: if (zero_i) begin
          cmd_o     <= CMD_REF;
          ref_cnt_q <= RC_W'(1);
          state_q   <= ST_REF;
        end
        ST_REF: if (zero_i) begin
          if (more_refs) begin
            cmd_o     <= CMD_REF;
            ref_cnt_q <= ref_cnt_q + 1'b1;
          end else begin
            cmd_o   <= CMD_LMR;
            addr_o  <= MODE_WORD;
            state_q <= ST_MRD;
          end
        end
        ST_MRD: if (zero_i) begin
          ready_o <= 1'b1;
          done_o  <= 1'b1;
          state_q <= ST_RUN;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sdram_refresh_gen.sv
module sdram_refresh_gen #(
  parameter int unsigned REFI_CYC = 782
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ack_i,
  output logic req_o
);

  localparam int unsigned RW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RW'(REFI_CYC - 1);
      req_o <= 1'b0;
    end else if (run_i) begin
      if (cnt_q == '0) begin
        cnt_q <= RW'(REFI_CYC - 1);
        req_o <= 1'b1;            // expiry wins over a same-cycle ack
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (ack_i) req_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned     ADDR_W       = 13,
  parameter int unsigned     BA_W         = 2,
  parameter int unsigned     WAIT_S_NS    = 100_000,
  parameter int unsigned     WAIT_L_NS    = 200_000,
  parameter int unsigned     REFS_S       = 2,
  parameter int unsigned     REFS_L       = 8,
  parameter int unsigned     TRP_NS       = 20,
  parameter int unsigned     TRFC_NS      = 66,
  parameter int unsigned     TMRD_NS      = 20,
  parameter int unsigned     REFI_NS      = 7812,
  parameter logic [ADDR_W-1:0] MODE_WORD  = 'h23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              refresh_ack_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ready_o,
  output logic              init_done_o,
  output logic              refresh_req_o
);

  localparam int unsigned WAIT_S_CYC = ns2cyc(WAIT_S_NS, CLK_HZ);
  localparam int unsigned WAIT_L_CYC = ns2cyc(WAIT_L_NS, CLK_HZ);
  localparam int unsigned TRP_CYC    = ns2cyc(TRP_NS, CLK_HZ);
  localparam int unsigned TRFC_CYC   = ns2cyc(TRFC_NS, CLK_HZ);
  localparam int unsigned TMRD_CYC   = ns2cyc(TMRD_NS, CLK_HZ);
  localparam int unsigned REFI_CYC   = ns2cyc(REFI_NS, CLK_HZ);
  localparam int unsigned MAX_CYC    = (WAIT_L_CYC > WAIT_S_CYC) ? WAIT_L_CYC : WAIT_S_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             zero;
  sdram_cmd_e       cmd;

  sdram_init_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sdram_init_fsm #(
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .CNT_W      (CNT_W),
    .WAIT_S_CYC (WAIT_S_CYC),
    .WAIT_L_CYC (WAIT_L_CYC),
    .REFS_S     (REFS_S),
    .REFS_L     (REFS_L),
    .TRP_CYC    (TRP_CYC),
    .TRFC_CYC   (TRFC_CYC),
    .TMRD_CYC   (TMRD_CYC),
    .MODE_WORD  (MODE_WORD)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .cke_o      (cke_o),
    .cmd_o      (cmd),
    .addr_o     (addr_o),
    .ba_o       (ba_o),
    .ready_o    (ready_o),
    .done_o     (init_done_o)
  );

  sdram_refresh_gen #(.REFI_CYC(REFI_CYC)) i_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ready_o),
    .ack_i  (refresh_ack_i),
    .req_o  (refresh_req_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int unsigned       ADDR_W    = 13,
  parameter int unsigned       BA_W      = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              refresh_ack_i,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BA_W-1:0]   ba_o,
  input logic              ready_o,
  input logic              init_done_o,
  input logic              refresh_req_o
);

  logic [3:0] cmd;
  assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  AST_CKE_STAYS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);                                                  // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0010) |-> addr_o[10]);                                  // R3
  AST_LMR_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0000) |-> (addr_o == MODE_WORD && ba_o == '0));         // R5
  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);                                              // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> !init_done_o);                                     // R7
  AST_DONE_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> init_done_o);                                   // R7
  AST_NO_REQ_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !refresh_req_o);                                      // R9
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_req_o && !refresh_ack_i) |=> refresh_req_o);              // R10
  AST_NOP_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cmd == 4'b0111));                                     // R11

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W    (ADDR_W),
  .BA_W      (BA_W),
  .MODE_WORD (MODE_WORD)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .refresh_ack_i (refresh_ack_i),
  .cke_o         (cke_o),
  .cs_n_o        (cs_n_o),
  .ras_n_o       (ras_n_o),
  .cas_n_o       (cas_n_o),
  .we_n_o        (we_n_o),
  .addr_o        (addr_o),
  .ba_o          (ba_o),
  .ready_o       (ready_o),
  .init_done_o   (init_done_o),
  .refresh_req_o (refresh_req_o)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int WAIT_S = 10000;
  localparam int WAIT_L = 20000;
  localparam int TRP    = 2;
  localparam int TRFC   = 7;
  localparam int TMRD   = 2;
  localparam int REFI   = 782;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic        refresh_ack_i = 1'b0;
  logic        cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [12:0] addr_o;
  logic [1:0]  ba_o;
  logic        ready_o, init_done_o, refresh_req_o;

  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;
  longint ready_cyc = 0;
  bit finished = 1'b0;

  sdram_init_seq i_sdram_init_seq (
    .clk_i, .rst_ni, .mode_i, .refresh_ack_i,
    .cke_o, .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o,
    .addr_o, .ba_o, .ready_o, .init_done_o, .refresh_req_o
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [3:0] cmd_now();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  function automatic logic [3:0] exp_cmd(int t, int w, int n);
    if (t == w) return 4'b0010;
    for (int k = 0; k < n; k++) if (t == w + TRP + k * TRFC) return 4'b0001;
    if (t == w + TRP + n * TRFC) return 4'b0000;
    return 4'b0111;
  endfunction

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    refresh_ack_i = 1'b0;
    repeat (3) step();
    check(cke_o == 1'b0, "R1 cke in reset", cke_o, 0);
    check(cmd_now() == 4'b1111, "R1 inhibit in reset", cmd_now(), 4'b1111);
    check(addr_o == '0, "R1 addr in reset", addr_o, 0);
    check(!ready_o && !init_done_o && !refresh_req_o, "R1 flags in reset",
          {ready_o, init_done_o, refresh_req_o}, 0);
  endtask

  // flip: toggle mode_i mid-sequence, which must have no effect (R8)
  task automatic test_init(input bit long_mode, input bit flip);
    int w, n, t_rdy, errs, first_t, nref, pre_t, lmr_t, done_cnt, rdy_t, early;
    logic [3:0] fa, fe;
    logic [12:0] lmr_addr;
    logic [1:0] lmr_ba;
    logic pre_a10;
    w = long_mode ? WAIT_L : WAIT_S;
    n = long_mode ? 8 : 2;
    t_rdy = w + TRP + n * TRFC + TMRD;
    errs = 0; first_t = -1; nref = 0; pre_t = -1; lmr_t = -1;
    done_cnt = 0; rdy_t = -1; early = 0; fa = '0; fe = '0;
    lmr_addr = '0; lmr_ba = '1; pre_a10 = 1'b0;
    mode_i = long_mode;
    rst_ni = 1'b1;
    for (int t = 0; t <= t_rdy + 1; t++) begin
      step();
      if (flip && t == 50) mode_i = ~long_mode;
      if (t == 0)
        check(cke_o && cmd_now() == 4'b0111, "R2 first cycle cke/NOP",
              {cke_o, cmd_now()}, 5'b10111);
      if (!cke_o || cmd_now() != exp_cmd(t, w, n)) begin
        if (errs == 0) begin first_t = t; fa = cmd_now(); fe = exp_cmd(t, w, n); end
        errs++;
      end
      if (cmd_now() == 4'b0010) begin pre_t = t; pre_a10 = addr_o[10]; end
      if (cmd_now() == 4'b0001) nref++;
      if (cmd_now() == 4'b0000) begin lmr_t = t; lmr_addr = addr_o; lmr_ba = ba_o; end
      if (init_done_o) done_cnt++;
      if (ready_o && rdy_t < 0) begin rdy_t = t; ready_cyc = cyc; end
      if (refresh_req_o) early++;
    end
    mode_i = 1'b0;
    if (errs != 0) $display("  first schedule mismatch at t=%0d", first_t);
    check(errs == 0, "R2 R4 command schedule", fa, fe);
    check(pre_t == w, "R3 precharge cycle", pre_t, w);
    check(pre_a10, "R3 precharge A10", pre_a10, 1);
    check(nref == n, flip ? "R8 refresh count after mode change" : "R4 refresh count", nref, n);
    check(lmr_t == w + TRP + n * TRFC, "R5 load-mode cycle", lmr_t, w + TRP + n * TRFC);
    check(lmr_addr == 13'h023 && lmr_ba == 2'b00, "R5 mode word", lmr_addr, 13'h023);
    check(rdy_t == t_rdy, "R6 R7 ready cycle", rdy_t, t_rdy);
    check(done_cnt == 1, "R7 done pulse width", done_cnt, 1);
    check(ready_o && !init_done_o, "R7 ready holds, done clears", {ready_o, init_done_o}, 2'b10);
    check(early == 0, "R9 no request before ready", early, 0);
  endtask

  task automatic test_refresh();
    longint rise;
    int bad_cmd;
    rise = -1; bad_cmd = 0;
    while (!refresh_req_o && cyc < ready_cyc + REFI + 10) begin
      step();
      if (cmd_now() != 4'b0111) bad_cmd++;
    end
    if (refresh_req_o) rise = cyc;
    check(rise - ready_cyc == REFI, "R9 first request delay", rise - ready_cyc, REFI);
    repeat (100) begin
      step();
      if (cmd_now() != 4'b0111) bad_cmd++;
    end
    check(refresh_req_o, "R10 request held without ack", refresh_req_o, 1);
    refresh_ack_i = 1'b1;
    step();
    refresh_ack_i = 1'b0;
    check(!refresh_req_o, "R10 request cleared by ack", refresh_req_o, 0);
    refresh_ack_i = 1'b1;
    step();
    refresh_ack_i = 1'b0;
    step();
    check(!refresh_req_o, "R10 ack while idle ignored", refresh_req_o, 0);
    rise = -1;
    while (!refresh_req_o && cyc < ready_cyc + 2 * REFI + 10) begin
      step();
      if (cmd_now() != 4'b0111) bad_cmd++;
    end
    if (refresh_req_o) rise = cyc;
    check(rise - ready_cyc == 2 * REFI, "R9 R10 second request period", rise - ready_cyc, 2 * REFI);
    check(bad_cmd == 0, "R11 only NOP after ready", bad_cmd, 0);
  endtask

  initial begin
    test_reset();
    test_init(1'b0, 1'b0);
    test_refresh();
    test_reset();
    test_init(1'b1, 1'b0);
    test_reset();
    test_init(1'b0, 1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule